// File: doc/BRIEF.md
# FIFO Status and Interrupt Register Unit

This unit sits next to a single-clock FIFO and turns the FIFO's condition into software-visible registers and one interrupt line. It watches the fill count, the full and empty flags, and the write and read strobes. From these it derives six status conditions every cycle: full, empty, almost-full, almost-empty, overflow and underflow. Each condition that is present sets a matching sticky event bit. Software clears an event bit by writing a one to it. The unit raises an interrupt when an enabled event bit goes from zero to one.

Software reaches six word registers through a small memory-mapped slave with separate read and write strobes. Read data is registered and is valid on the cycle after the read strobe. The two thresholds can be rewritten at any time. Each write is clamped into the legal range for the configured depth, so the status comparisons always work against a sane limit.

Top module: `fifo_stat_irq`

## Requirements
- R1: After reset the almost-full threshold is DEPTH-1, the almost-empty threshold is 1, the event and enable registers are 0, and `irq` is 0.
- R2: Word offsets are 0 fill count, 1 status, 2 event, 3 enable, 4 almost-full threshold, 5 almost-empty threshold. Offsets 6 and 7 read 0. Bits 31:6 of status, event and enable read 0. `bus_rdata` is loaded on the cycle after `bus_rd` is high.
- R3: Status bit 0 mirrors `fifo_full` and bit 1 mirrors `fifo_empty`.
- R4: Status bit 2 is 1 only when the fill count is strictly above the almost-full threshold. Status bit 3 is 1 only when the fill count is strictly below the almost-empty threshold.
- R5: Status bit 4 (overflow) is 1 in exactly the cycles where `fifo_wr` and `fifo_full` are both high. Status bit 5 (underflow) is 1 in exactly the cycles where `fifo_rd` and `fifo_empty` are both high.
- R6: A status bit that is 1 in a cycle sets its event bit at the next clock edge. An event bit stays 1 until it is cleared by a write.
- R7: Writing offset 2 clears each event bit whose data bit is 1. If the status bit is 1 in that same cycle, the event bit stays 1.
- R8: `irq` goes high one cycle after an event bit rises from 0 to 1 while its enable bit (offset 3, bits 5:0) is set. An event bit that is already 1 raises no new interrupt.
- R9: Once high, `irq` stays high until no event bit is both set and enabled. Clearing those event bits or their enable bits drops `irq` at the next edge.
- R10: A write to the almost-full threshold stores 1 if the value is below 1. It stores DEPTH-1 if the value is above DEPTH-1. Otherwise it stores the written value.
- R11: A write to the almost-empty threshold is clamped the same way, to the range 1 to DEPTH-1.
- R12: Offset 0 returns the current `fifo_fill` value, zero-extended. Writes to offsets 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_fill | input | $clog2(DEPTH+1) | Current number of stored words |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_wr | input | 1 | Write strobe into the FIFO |
| fifo_rd | input | 1 | Read strobe from the FIFO |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
Several properties are checked on every cycle. The two thresholds always stay inside 1 to DEPTH-1. Event bits never drop without a matching clear. Every active status bit is recorded in the event register at the next edge. An enabled rising event always raises `irq`. `irq` is never high when no event is both set and enabled. Other behaviour only shows in the bench's scenarios: the strict threshold comparisons at their boundary values, the clamping of out-of-range writes, set-over-clear priority when both happen in one cycle, and the absence of an interrupt for an event bit that was already set.

// File: rtl/fifo_stat_irq.sv
module fifo_stat_irq #(
  parameter int DEPTH  = 16,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] fifo_fill,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              fifo_wr,
  input  logic              fifo_rd,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [31:0]       THR_MAX  = 32'(DEPTH - 1);
  localparam logic [FILL_W-1:0] THR_MAXF = FILL_W'(DEPTH - 1);
  localparam logic [FILL_W-1:0] THR_ONE  = FILL_W'(1);

  logic [FILL_W-1:0] af_thr, ae_thr;
  logic [5:0] stat, ev_q, ev_n, ien_q, ien_n, clr_mask;
  logic wr_ev, wr_ien, wr_af, wr_ae;

  assign wr_ev  = bus_wr && bus_addr == 3'd2;
  assign wr_ien = bus_wr && bus_addr == 3'd3;
  assign wr_af  = bus_wr && bus_addr == 3'd4;
  assign wr_ae  = bus_wr && bus_addr == 3'd5;

  assign stat[0] = fifo_full;
  assign stat[1] = fifo_empty;
  assign stat[2] = fifo_fill > af_thr;
  assign stat[3] = fifo_fill < ae_thr;
  assign stat[4] = fifo_wr & fifo_full;
  assign stat[5] = fifo_rd & fifo_empty;

  assign clr_mask = wr_ev ? bus_wdata[5:0] : 6'd0;
  assign ev_n     = (ev_q & ~clr_mask) | stat;
  assign ien_n    = wr_ien ? bus_wdata[5:0] : ien_q;

  function automatic logic [FILL_W-1:0] clamp_thr(input logic [31:0] v);
    if (v < 32'd1)        return THR_ONE;
    else if (v > THR_MAX) return THR_MAXF;
    else                  return v[FILL_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= '0;
      ien_q  <= '0;
      af_thr <= THR_MAXF;
      ae_thr <= THR_ONE;
      irq    <= 1'b0;
    end else begin
      ev_q  <= ev_n;
      ien_q <= ien_n;
      if (wr_af) af_thr <= clamp_thr(bus_wdata);
      if (wr_ae) ae_thr <= clamp_thr(bus_wdata);
      irq <= (|(stat & ~ev_q & ien_q)) | (irq & |(ev_n & ien_n));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        3'd0:    bus_rdata <= 32'(fifo_fill);
        3'd1:    bus_rdata <= 32'(stat);
        3'd2:    bus_rdata <= 32'(ev_q);
        3'd3:    bus_rdata <= 32'(ien_q);
        3'd4:    bus_rdata <= 32'(af_thr);
        3'd5:    bus_rdata <= 32'(ae_thr);
        default: bus_rdata <= '0;
      endcase
    end
  end

  p_af_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (af_thr >= THR_ONE) && (af_thr <= THR_MAXF));
  p_ae_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ae_thr >= THR_ONE) && (ae_thr <= THR_MAXF));
  p_ev_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_q) & ~$past(clr_mask) & ~ev_q) == 6'd0));
  p_ev_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat) & ~ev_q) == 6'd0));
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~ev_q & ien_q)) |=> irq);
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(ev_q & ien_q)) |-> !irq);
  p_ovf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat[4] |-> fifo_full);
endmodule

// File: tb/fifo_stat_irq_tb.sv
`timescale 1ns/1ps
module fifo_stat_irq_tb;
  localparam int DEPTH = 16;
  localparam int FW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [FW-1:0] fifo_fill = '0;
  logic fifo_full = 1'b0, fifo_empty = 1'b1, fifo_wr = 1'b0, fifo_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  fifo_stat_irq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_fill(fifo_fill), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic quiet(input int fill);
    @(negedge clk);
    fifo_fill = FW'(fill); fifo_full = 1'b0; fifo_empty = 1'b0;
    fifo_wr = 1'b0; fifo_rd = 1'b0;
  endtask

  task automatic pulse_ovf();
    @(negedge clk); fifo_full = 1'b1; fifo_wr = 1'b1;
    @(negedge clk); fifo_full = 1'b0; fifo_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 32'd0);
    rd(3'd4, d); check("R1 af reset", d, 32'(DEPTH-1));
    rd(3'd5, d); check("R1 ae reset", d, 32'd1);
    rd(3'd3, d); check("R1 ien reset", d, 32'd0);
    rd(3'd6, d); check("R2 unused 6", d, 32'd0);
    rd(3'd7, d); check("R2 unused 7", d, 32'd0);
  endtask

  task automatic t_fill();
    logic [31:0] d;
    quiet(7); rd(3'd0, d); check("R12 fill 7", d, 32'd7);
    wr(3'd0, 32'hFFFF); rd(3'd0, d); check("R12 fill write ignored", d, 32'd7);
    wr(3'd1, 32'h3F); rd(3'd1, d); check("R12 status write ignored", d, 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); fifo_fill = '0; fifo_empty = 1'b1; fifo_full = 1'b0;
    rd(3'd1, d); check("R3 R4 empty+ae", d, 32'h0A);
    @(negedge clk); fifo_fill = FW'(16); fifo_empty = 1'b0; fifo_full = 1'b1;
    rd(3'd1, d); check("R3 R4 full+af", d, 32'h05);
    quiet(15); rd(3'd1, d); check("R4 af strict at thr", d, 32'h00);
    quiet(1);  rd(3'd1, d); check("R4 ae strict at thr", d, 32'h00);
    wr(3'd5, 32'd4);
    quiet(3);  rd(3'd1, d); check("R4 ae below 4", d, 32'h08);
    quiet(4);  rd(3'd1, d); check("R4 ae equal 4", d, 32'h00);
    wr(3'd5, 32'd1);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    wr(3'd4, 32'd0);   rd(3'd4, d); check("R10 af low clamp", d, 32'd1);
    wr(3'd4, 32'd100); rd(3'd4, d); check("R10 af high clamp", d, 32'(DEPTH-1));
    wr(3'd4, 32'h8000_0008); rd(3'd4, d); check("R10 af wide clamp", d, 32'(DEPTH-1));
    wr(3'd4, 32'd8);   rd(3'd4, d); check("R10 af in range", d, 32'd8);
    wr(3'd5, 32'd0);   rd(3'd5, d); check("R11 ae low clamp", d, 32'd1);
    wr(3'd5, 32'd50);  rd(3'd5, d); check("R11 ae high clamp", d, 32'(DEPTH-1));
    wr(3'd5, 32'd3);   rd(3'd5, d); check("R11 ae in range", d, 32'd3);
    wr(3'd4, 32'(DEPTH-1)); wr(3'd5, 32'd1);
  endtask

  task automatic t_events();
    logic [31:0] d;
    quiet(8); wr(3'd2, 32'h3F);
    rd(3'd2, d); check("R7 clear all", d, 32'd0);
    pulse_ovf();
    rd(3'd2, d); check("R5 R6 ovf event", d, 32'h11);
    rd(3'd1, d); check("R5 ovf one cycle", d, 32'h00);
    @(negedge clk); fifo_empty = 1'b1; fifo_rd = 1'b1;
    @(negedge clk); fifo_empty = 1'b0; fifo_rd = 1'b0;
    rd(3'd2, d); check("R5 R6 udf event", d, 32'h33);
    wr(3'd2, 32'h01);
    rd(3'd2, d); check("R7 partial clear", d, 32'h32);
    @(negedge clk); fifo_empty = 1'b1;
    wr(3'd2, 32'h02);
    rd(3'd2, d); check("R7 set wins", d, 32'h32);
    quiet(8); wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R2 event upper zero", d, 32'd0);
    wr(3'd3, 32'hFFFF_FFC0);
    rd(3'd3, d); check("R2 enable upper zero", d, 32'd0);
  endtask

  task automatic t_irq();
    quiet(8); wr(3'd2, 32'h3F); wr(3'd3, 32'h10);
    check("R9 irq idle", 32'(irq), 32'd0);
    pulse_ovf();
    check("R8 irq on ovf", 32'(irq), 32'd1);
    wr(3'd2, 32'h01);
    check("R9 irq held", 32'(irq), 32'd1);
    wr(3'd2, 32'h10);
    check("R9 irq cleared", 32'(irq), 32'd0);
    wr(3'd3, 32'h00); pulse_ovf();
    check("R8 disabled no irq", 32'(irq), 32'd0);
    wr(3'd3, 32'h10);
    @(negedge clk); check("R8 enable on set event", 32'(irq), 32'd0);
    pulse_ovf();
    check("R8 no edge no irq", 32'(irq), 32'd0);
    wr(3'd2, 32'h3F); pulse_ovf();
    check("R8 irq again", 32'(irq), 32'd1);
    wr(3'd3, 32'h00);
    check("R9 disable drops irq", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_status();
    t_thresh();
    t_events();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule